// File: doc/BRIEF.md
# Reset-Driven Power-State Sequencer

This block follows the device through its four power-management states: the reset state, active-but-uninitialized, fully active, and the D3 low-power state. The active-low platform reset pin drives the moves into and out of the reset state. Software requests drive the moves among the other three states. All functions of the device share the platform reset pin, so the whole device enters and leaves the reset state together.

While the block sits in the reset state, it tells the wake-filter logic to keep the settings it already has. It also decides whether the device stays partly powered or drops into a minimal-power disable mode. The device stays partly powered if any function still has wake enabled, or if pass-through manageability is on.

The reset pin is asynchronous to the block clock. It passes through a synchronizer chain before any edge is detected. An internal power-on reset clears the block asynchronously. A rising edge of the power-good signal sends the block back to the reset state from any state.

Top module: `pwr_state_seq`

## Requirements
- R1: While and after the internal power-on reset, the state output reads 2'b11 (reset state). The encoding of the other states is 2'b00 = active uninitialized, 2'b01 = active, 2'b10 = D3.
- R2: In the reset state, the state output stays at 2'b11 for as long as the platform reset pin is held low, with no timeout.
- R3: In the reset state, a rising edge on the platform reset pin moves the state to 2'b00. The new state appears on the third rising clock edge after the pin changes, with the default two-stage synchronizer. It does not appear earlier.
- R4: In the active state (2'b01), a low platform reset pin moves the state to 2'b11 with the same three-edge latency.
- R5: In D3 (2'b10), a low platform reset pin moves the state to 2'b11 with the same three-edge latency.
- R6: A rising edge of the power-good input moves the state to 2'b11 on the next clock edge, from any state. The block then stays in the reset state until the platform reset pin next rises, even if the pin is already high.
- R7: Software requests act on the next clock edge, as follows:
  - The go-active request moves 2'b00 to 2'b01 and moves 2'b10 to 2'b00.
  - The go-D3 request moves 2'b01 to 2'b10.
  - Every other request/state combination is ignored. This includes any request made in the reset state.
- R8: The wake-filter retain output is high exactly while the state output reads 2'b11.
- R9: The disable-mode output is high only in the reset state, with every wake-enable bit low and manageability off. It follows changes to those inputs one clock edge later.
- R10: On the edge that leaves the reset state, the disable-mode and retain outputs go low in the same cycle as the state output changes to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_i | input | 1 | Internal power-on reset, active high, asynchronous |
| pwr_good_i | input | 1 | Power-good indication; its rising edge forces the reset state |
| plat_rst_n_i | input | 1 | Platform reset pin, active low, asynchronous |
| wake_en_i | input | NUM_FUNC | Per-function wake-on-LAN enable flags |
| mng_en_i | input | 1 | Pass-through manageability enable |
| sw_to_active_i | input | 1 | Software request: go to the active state (or from D3, back to uninitialized) |
| sw_to_d3_i | input | 1 | Software request: go from the active state to D3 |
| state_o | output | 2 | Current power state, encoded as in R1 |
| dis_mode_o | output | 1 | Minimal-power disable mode indicator |
| wake_keep_o | output | 1 | Retain wake-filter settings |

## Verification
The assertions check the following on every cycle:
- The retain and disable outputs are consistent with the state.
- The disable output never rises while a wake or manageability flag was set.
- The reset state is never left while the synchronized pin is low.
- A low pin always pulls a non-reset state into reset.
- Uninitialized is only entered from reset or D3.

The bench scenarios are needed to show three things:
- The exact three-edge pin latency.
- That the reset state holds across a long low pin.
- That a power-good edge leaves the block waiting for a fresh pin rise.

The bench also sweeps every wake/manageability combination to show the disable decision.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   typedef enum logic [1:0] {
      PS_D0U = 2'b00,
      PS_D0A = 2'b01,
      PS_D3  = 2'b10,
      PS_RST = 2'b11
   } pstate_e;

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic arst_i,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwrseq_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or posedge arst_i) begin
               if (arst_i) chain_q[0] <= RESET_VAL;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or posedge arst_i) begin
               if (arst_i) chain_q[s] <= RESET_VAL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwrseq_quiet.sv
module pwrseq_quiet #(
   parameter int NUM_FUNC = 2
) (
   input  logic [NUM_FUNC-1:0] wake_en_i,
   input  logic                mng_en_i,
   output logic                quiet_o
);

   logic [NUM_FUNC:0] any_q;

   generate
      if (NUM_FUNC < 1) begin : g_bad_func
         $error("pwrseq_quiet: NUM_FUNC must be at least 1");
      end
   endgenerate

   assign any_q[0] = mng_en_i;
   for (genvar f = 0; f < NUM_FUNC; f++) begin : g_or
      assign any_q[f+1] = any_q[f] | wake_en_i[f];
   end

   assign quiet_o = ~any_q[NUM_FUNC];

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
   import pwrseq_pkg::*;
(
   input  logic       clk_i,
   input  logic       arst_i,
   input  logic       pin_s_i,
   input  logic       pg_i,
   input  logic       sw_act_i,
   input  logic       sw_d3_i,
   input  logic       quiet_i,
   output logic [1:0] state_o,
   output logic       dis_o,
   output logic       keep_o
);

   pstate_e st_q, st_nxt;
   logic    pin_d_q;
   logic    pg_d_q;
   logic    dis_q;
   logic    pin_rise;
   logic    pg_rise;

   assign pin_rise = pin_s_i & ~pin_d_q;
   assign pg_rise  = pg_i & ~pg_d_q;

   always_comb begin
      st_nxt = st_q;
      if (pg_rise) begin
         st_nxt = PS_RST;
      end else if (st_q == PS_RST) begin
         if (pin_rise) st_nxt = PS_D0U;
      end else if (!pin_s_i) begin
         st_nxt = PS_RST;
      end else begin
         case (st_q)
            PS_D0U:  if (sw_act_i) st_nxt = PS_D0A;
            PS_D0A:  if (sw_d3_i)  st_nxt = PS_D3;
            PS_D3:   if (sw_act_i) st_nxt = PS_D0U;
            default: st_nxt = st_q;
         endcase
      end
   end

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) begin
         st_q    <= PS_RST;
         pin_d_q <= 1'b0;
         pg_d_q  <= 1'b0;
         dis_q   <= 1'b0;
      end else begin
         st_q    <= st_nxt;
         pin_d_q <= pin_s_i;
         pg_d_q  <= pg_i;
         dis_q   <= (st_nxt == PS_RST) && quiet_i;
      end
   end

   assign state_o = st_q;
   assign dis_o   = dis_q;
   assign keep_o  = (st_q == PS_RST);

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq #(
   parameter int NUM_FUNC    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                por_i,
   input  logic                pwr_good_i,
   input  logic                plat_rst_n_i,
   input  logic [NUM_FUNC-1:0] wake_en_i,
   input  logic                mng_en_i,
   input  logic                sw_to_active_i,
   input  logic                sw_to_d3_i,
   output logic [1:0]          state_o,
   output logic                dis_mode_o,
   output logic                wake_keep_o
);

   logic pin_sync;
   logic all_quiet;

   pwrseq_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b0)
   ) u_pin_sync (
      .clk_i  (clk_i),
      .arst_i (por_i),
      .d_i    (plat_rst_n_i),
      .q_o    (pin_sync)
   );

   pwrseq_quiet #(
      .NUM_FUNC (NUM_FUNC)
   ) u_quiet (
      .wake_en_i (wake_en_i),
      .mng_en_i  (mng_en_i),
      .quiet_o   (all_quiet)
   );

   pwrseq_fsm u_fsm (
      .clk_i    (clk_i),
      .arst_i   (por_i),
      .pin_s_i  (pin_sync),
      .pg_i     (pwr_good_i),
      .sw_act_i (sw_to_active_i),
      .sw_d3_i  (sw_to_d3_i),
      .quiet_i  (all_quiet),
      .state_o  (state_o),
      .dis_o    (dis_mode_o),
      .keep_o   (wake_keep_o)
   );

endmodule

// File: rtl/pwr_state_seq_chk.sv
module pwr_state_seq_chk #(
   parameter int NUM_FUNC = 2
) (
   input logic                clk_i,
   input logic                por_i,
   input logic [NUM_FUNC-1:0] wake_en_i,
   input logic                mng_en_i,
   input logic [1:0]          state_o,
   input logic                dis_mode_o,
   input logic                wake_keep_o,
   input logic                pin_s
);

   // R8: retain output tracks the reset state
   assert_keep_tracks_state_R8: assert property (@(posedge clk_i) disable iff (por_i)
      wake_keep_o == (state_o == 2'b11));

   // R9: disable mode only inside the reset state
   assert_dis_in_reset_R9: assert property (@(posedge clk_i) disable iff (por_i)
      dis_mode_o |-> state_o == 2'b11);

   // R9: disable mode never follows an active wake or manageability flag
   assert_dis_quiet_R9: assert property (@(posedge clk_i) disable iff (por_i)
      dis_mode_o |-> ($past(wake_en_i) == '0 && !$past(mng_en_i)));

   // R2: reset state is held while the synchronized pin is low
   assert_hold_reset_R2: assert property (@(posedge clk_i) disable iff (por_i)
      (state_o == 2'b11 && !pin_s) |=> state_o == 2'b11);

   // R4 / R5: a low pin pulls any other state into reset
   assert_pin_low_enters_R4: assert property (@(posedge clk_i) disable iff (por_i)
      (state_o != 2'b11 && !pin_s) |=> state_o == 2'b11);

   // R10: leaving reset clears both indicators together
   assert_exit_clears_R10: assert property (@(posedge clk_i) disable iff (por_i)
      ($past(state_o) == 2'b11 && state_o != 2'b11) |-> (!dis_mode_o && !wake_keep_o));

   // R7: uninitialized is reached only from reset or D3
   assert_d0u_origin_R7: assert property (@(posedge clk_i) disable iff (por_i)
      (state_o == 2'b00 && $past(state_o) != 2'b00) |->
      ($past(state_o) == 2'b11 || $past(state_o) == 2'b10));

endmodule

bind pwr_state_seq pwr_state_seq_chk #(.NUM_FUNC(NUM_FUNC)) u_chk (
   .clk_i       (clk_i),
   .por_i       (por_i),
   .wake_en_i   (wake_en_i),
   .mng_en_i    (mng_en_i),
   .state_o     (state_o),
   .dis_mode_o  (dis_mode_o),
   .wake_keep_o (wake_keep_o),
   .pin_s       (pin_sync)
);

// File: tb/test_pwr_state_seq.sv
`timescale 1ns/1ps
module test_pwr_state_seq;

   localparam int NF = 2;

   logic          clk = 1'b0;
   logic          por;
   logic          pg;
   logic          pin_n;
   logic [NF-1:0] wake;
   logic          mng;
   logic          go_act;
   logic          go_d3;
   logic [1:0]    st;
   logic          dis;
   logic          keep;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pwr_state_seq #(.NUM_FUNC(NF), .SYNC_STAGES(2)) i_pwr_state_seq (
      .clk_i          (clk),
      .por_i          (por),
      .pwr_good_i     (pg),
      .plat_rst_n_i   (pin_n),
      .wake_en_i      (wake),
      .mng_en_i       (mng),
      .sw_to_active_i (go_act),
      .sw_to_d3_i     (go_d3),
      .state_o        (st),
      .dis_mode_o     (dis),
      .wake_keep_o    (keep)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_st(input string req, input logic [1:0] exp);
      chk(req, int'(st), int'(exp));
      chk({req, " keep"}, int'(keep), int'(exp == 2'b11));
   endtask

   task automatic pulse_act();
      go_act = 1'b1; step(1); go_act = 1'b0;
   endtask

   task automatic pulse_d3();
      go_d3 = 1'b1; step(1); go_d3 = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      por = 1'b1; pg = 1'b1; pin_n = 1'b0; wake = '0; mng = 1'b0;
      go_act = 1'b0; go_d3 = 1'b0;
      step(3);
      chk_st("R1 during por", 2'b11);
      por = 1'b0;
      step(2);
      chk_st("R1 after por", 2'b11);
      chk("R1 dis quiet", int'(dis), 1);

      // R9 sweep of all wake/manageability combinations in reset
      for (int c = 0; c < (1 << (NF + 1)); c++) begin
         {mng, wake} = c[NF:0];
         step(1);
         chk("R9 sweep", int'(dis), int'(c == 0));
      end
      {mng, wake} = '0;
      step(1);

      // R2 long hold
      for (int k = 0; k < 20; k++) begin
         step(100);
         chk_st("R2 long hold", 2'b11);
      end

      // R3 latency and R10 exit
      pin_n = 1'b1;
      step(2);
      chk_st("R3 not early", 2'b11);
      chk("R3 dis before exit", int'(dis), 1);
      step(1);
      chk_st("R3 exit to d0u", 2'b00);
      chk("R10 dis cleared", int'(dis), 0);

      // R7 software transitions
      pulse_d3();
      chk_st("R7 d3 ignored in d0u", 2'b00);
      pulse_act();
      chk_st("R7 d0u to d0a", 2'b01);
      pulse_act();
      chk_st("R7 act ignored in d0a", 2'b01);
      pulse_d3();
      chk_st("R7 d0a to d3", 2'b10);
      pulse_d3();
      chk_st("R7 d3 ignored in d3", 2'b10);
      pulse_act();
      chk_st("R7 d3 to d0u", 2'b00);
      pulse_act();
      pulse_d3();
      chk_st("R7 back in d3", 2'b10);

      // R5 pin low in D3
      pin_n = 1'b0;
      step(2);
      chk_st("R5 not early", 2'b10);
      step(1);
      chk_st("R5 d3 to reset", 2'b11);
      chk("R5 dis", int'(dis), 1);
      pin_n = 1'b1;
      step(3);
      chk_st("R3 second exit", 2'b00);
      pulse_act();
      chk_st("R7 to d0a", 2'b01);

      // R4 pin low in D0A, with a wake flag set (R9 not disabled)
      wake = 2'b10;
      pin_n = 1'b0;
      step(3);
      chk_st("R4 d0a to reset", 2'b11);
      chk("R9 wake keeps alive", int'(dis), 0);
      pulse_act();
      chk_st("R7 act ignored in reset", 2'b11);
      pulse_d3();
      chk_st("R7 d3 ignored in reset", 2'b11);
      wake = '0;
      step(1);
      chk("R9 wake dropped", int'(dis), 1);
      pin_n = 1'b1;
      step(3);
      chk_st("R3 third exit", 2'b00);
      chk("R10 dis cleared again", int'(dis), 0);
      pulse_act();

      // R6 power-good edge
      pg = 1'b0;
      step(1);
      chk_st("R6 pg fall no effect", 2'b01);
      pg = 1'b1;
      step(1);
      chk_st("R6 pg rise to reset", 2'b11);
      step(20);
      chk_st("R6 waits for pin rise", 2'b11);
      pulse_act();
      chk_st("R6 sw ignored", 2'b11);
      pin_n = 1'b0;
      step(3);
      pin_n = 1'b1;
      step(3);
      chk_st("R6 exit after pin rise", 2'b00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule